// File: doc/BRIEF.md
# Panel Power Sequencer

This block brings up an embedded display panel in a fixed order. Software first writes a 32-bit configuration word. The word names the port that carries the panel and gives two delays. A power request then starts the sequence. The block first checks that the chosen port is a legal code, that the port is enabled and that it is routed to the correct display pipe. If all three hold, it switches panel power on. After the first delay it flags the panel as ready, and after the second delay it turns on the backlight.

Both delays count periods of a 100 microsecond timebase. A prescaler derives this timebase from the system clock and restarts each time a sequence begins, so delays are measured from the moment the sequence starts. The block falls back to the off state at once when the request is withdrawn or the port stops being usable. A sticky flag records any request that was refused because the port was invalid.

Top module: `pps_seq_top`

## Requirements
- R1: The configuration word has three fields. Bits 31:30 select the port, bits 28:16 hold the power-up delay D1, and bits 12:0 hold the backlight delay D2. Bits 29 and 15:13 have no effect. The word resets to all zeros, so a request made right after reset is refused.
- R2: Port code 01 uses status index 0 and code 10 uses status index 1. A port is valid only when both port_en and port_pipe_ok are high at its index. Codes 00 and 11 never let panel power turn on.
- R3: A request made while idle with a valid port raises panel_pwr one clock later, and seq_status reads 01 (in progress).
- R4: A tick occurs every CLK_KHZ/10 clocks. Tick counting restarts when a sequence starts. panel_rdy rises on tick number max(D1,1) after the start.
- R5: backlight_en rises max(D2,1) ticks after panel_rdy rises. seq_status then reads 10 (on).
- R6: A delay field of zero advances the sequence on the very next tick.
- R7: If pwr_req drops, or the port becomes invalid, while the sequencer is not idle, then one clock later panel_pwr, panel_rdy and backlight_en are all low and seq_status reads 00.
- R8: The delays are captured when a sequence starts. A write made during a sequence does not change the timing of that sequence.
- R9: blocked_flag sets when a request is made while idle with an invalid port. It stays set until the next configuration write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word being written |
| pwr_req | input | 1 | Software request for panel power |
| port_en | input | 2 | Per-port enabled status |
| port_pipe_ok | input | 2 | Per-port routed-to-correct-pipe status |
| panel_pwr | output | 1 | Panel power enable |
| panel_rdy | output | 1 | Power-up delay has elapsed |
| backlight_en | output | 1 | Backlight enable |
| seq_status | output | 2 | 00 idle, 01 in progress, 10 on |
| blocked_flag | output | 1 | Sticky flag for a refused request |

## Verification
The bench sweeps every combination of port code, enable status and pipe status. A design that decoded the port select wrongly, or ignored one of the status bits, would power a panel it should refuse, or would fail to set the blocked flag. The bench also sweeps delay pairs that include zero and the largest 13-bit value, and measures the clock at which each output rises. An off-by-one in the countdown, a zero delay that waits forever, or a prescaler left running in its old phase all move these edges by a countable number of clocks. Further tests rewrite the delays mid-sequence, set the reserved bits, and withdraw the request or the port status in each active state. These catch live delay use, leaking reserved bits and a slow shutdown.

// File: rtl/pps_pkg.sv
package pps_pkg;
   typedef enum logic [1:0] {
      S_OFF    = 2'd0,
      S_PWRUP  = 2'd1,
      S_WAITBL = 2'd2,
      S_ON     = 2'd3
   } pps_state_e;

   localparam int SEL_LSB   = 30;
   localparam int UPD_LSB   = 16;
   localparam int BLD_LSB   = 0;
   localparam int FIELD_MAX = 13;

   localparam logic [1:0] STAT_IDLE = 2'b00;
   localparam logic [1:0] STAT_BUSY = 2'b01;
   localparam logic [1:0] STAT_ON   = 2'b10;
endpackage

// File: rtl/pps_cfg_reg.sv
module pps_cfg_reg
   import pps_pkg::*;
#(
   parameter int DLY_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [31:0]      wdata,
   output logic [1:0]       sel,
   output logic [DLY_W-1:0] up_dly,
   output logic [DLY_W-1:0] bl_dly
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel    <= '0;
         up_dly <= '0;
         bl_dly <= '0;
      end else if (wr) begin
         sel    <= wdata[SEL_LSB +: 2];
         up_dly <= wdata[UPD_LSB +: DLY_W];
         bl_dly <= wdata[BLD_LSB +: DLY_W];
      end
   end

   // R1: without a write the fields keep their value
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> ($stable(sel) && $stable(up_dly) && $stable(bl_dly)));
endmodule

// File: rtl/pps_tick_gen.sv
module pps_tick_gen #(
   parameter int DIV = 12500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_div1
         assign tick = ~clr;
      end else begin : g_divn
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n || clr) cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else cnt_q <= cnt_q + 1'b1;
         end

         assign tick = !clr && (cnt_q == LAST);

         // R4: ticks are single-cycle pulses
         a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
   import pps_pkg::*;
#(
   parameter int DLY_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             pwr_req,
   input  logic             port_ok,
   input  logic             cfg_wr,
   input  logic [DLY_W-1:0] up_dly,
   input  logic [DLY_W-1:0] bl_dly,
   output pps_state_e       state,
   output logic             blocked
);
   localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

   pps_state_e       state_q;
   logic [DLY_W-1:0] cnt_q;
   logic [DLY_W-1:0] bl_q;
   logic             blocked_q;
   logic             keep;
   logic             done;

   assign keep = pwr_req && port_ok;
   assign done = tick && (cnt_q <= ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_OFF;
         cnt_q   <= '0;
         bl_q    <= '0;
      end else if (state_q == S_OFF) begin
         if (keep) begin
            state_q <= S_PWRUP;
            cnt_q   <= up_dly;
            bl_q    <= bl_dly;
         end
      end else if (!keep) begin
         state_q <= S_OFF;
      end else begin
         case (state_q)
            S_PWRUP: begin
               if (done) begin
                  state_q <= S_WAITBL;
                  cnt_q   <= bl_q;
               end else if (tick) begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            S_WAITBL: begin
               if (done) state_q <= S_ON;
               else if (tick) cnt_q <= cnt_q - 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) blocked_q <= 1'b0;
      else if (state_q == S_OFF && pwr_req && !port_ok) blocked_q <= 1'b1;
      else if (cfg_wr) blocked_q <= 1'b0;
   end

   assign state   = state_q;
   assign blocked = blocked_q;

   a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != S_OFF && !keep) |=> state_q == S_OFF);
   a_r2_invalid_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_OFF && !port_ok) |=> state_q == S_OFF);
   a_r4_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != S_OFF && !tick && keep) |=> $stable(state_q));
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (blocked_q && !cfg_wr) |=> blocked_q);
endmodule

// File: rtl/pps_seq_top.sv
module pps_seq_top
   import pps_pkg::*;
#(
   parameter int CLK_KHZ = 125000,
   parameter int DLY_W   = 13
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic [31:0] cfg_wdata,
   input  logic        pwr_req,
   input  logic [1:0]  port_en,
   input  logic [1:0]  port_pipe_ok,
   output logic        panel_pwr,
   output logic        panel_rdy,
   output logic        backlight_en,
   output logic [1:0]  seq_status,
   output logic        blocked_flag
);
   localparam int TICK_DIV = CLK_KHZ / 10;

   generate
      if (CLK_KHZ < 10 || (CLK_KHZ % 10) != 0) begin : g_bad_clk
         $error("CLK_KHZ must be a positive multiple of 10");
      end
      if (DLY_W < 1 || DLY_W > FIELD_MAX) begin : g_bad_width
         $error("DLY_W must lie in 1..13");
      end
   endgenerate

   logic [1:0]       sel;
   logic [DLY_W-1:0] up_dly;
   logic [DLY_W-1:0] bl_dly;
   logic             port_ok;
   logic             tick;
   pps_state_e       state;

   pps_cfg_reg #(.DLY_W(DLY_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
      .sel(sel), .up_dly(up_dly), .bl_dly(bl_dly)
   );

   always_comb begin
      case (sel)
         2'b01:   port_ok = port_en[0] && port_pipe_ok[0];
         2'b10:   port_ok = port_en[1] && port_pipe_ok[1];
         default: port_ok = 1'b0;
      endcase
   end

   pps_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(state == S_OFF), .tick(tick)
   );

   pps_fsm #(.DLY_W(DLY_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_req(pwr_req),
      .port_ok(port_ok), .cfg_wr(cfg_wr), .up_dly(up_dly), .bl_dly(bl_dly),
      .state(state), .blocked(blocked_flag)
   );

   assign panel_pwr    = (state != S_OFF);
   assign panel_rdy    = (state == S_WAITBL) || (state == S_ON);
   assign backlight_en = (state == S_ON);
   assign seq_status   = (state == S_OFF) ? STAT_IDLE :
                         (state == S_ON)  ? STAT_ON   : STAT_BUSY;

   // R2: reserved port codes never bring up panel power
   a_r2_reserved_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (!panel_pwr && (sel == 2'b00 || sel == 2'b11)) |=> !panel_pwr);
   // R5: backlight only comes on from the ready phase
   a_r5_bl_after_rdy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(backlight_en) |-> $past(panel_rdy));
endmodule

// File: tb/tb_pps_seq_top.sv
module tb_pps_seq_top;
   localparam int CLK_KHZ = 40;
   localparam int DIV     = CLK_KHZ / 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        pwr_req = 1'b0;
   logic [1:0]  port_en = 2'b00;
   logic [1:0]  port_pipe_ok = 2'b00;
   logic        panel_pwr, panel_rdy, backlight_en, blocked_flag;
   logic [1:0]  seq_status;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   pps_seq_top #(.CLK_KHZ(CLK_KHZ), .DLY_W(13)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .pwr_req(pwr_req), .port_en(port_en), .port_pipe_ok(port_pipe_ok),
      .panel_pwr(panel_pwr), .panel_rdy(panel_rdy), .backlight_en(backlight_en),
      .seq_status(seq_status), .blocked_flag(blocked_flag)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int mx1(input int d);
      return (d == 0) ? 1 : d;
   endfunction

   task automatic wr_cfg(input int sel, input int d1, input int d2, input logic [31:0] extra);
      cfg_wdata = (32'(sel) << 30) | (32'(d1) << 16) | 32'(d2) | extra;
      cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   // start a sequence on port 0 and measure the rise of each output
   task automatic run_seq(input int d1, input int d2, input bit midwr, input string req);
      int t_pwr = -1, t_rdy = -1, t_bl = -1;
      int lim = 1 + (mx1(d1) + mx1(d2)) * DIV + 6;
      int e_rdy = 1 + mx1(d1) * DIV;
      int e_bl  = e_rdy + mx1(d2) * DIV;
      port_en = 2'b11; port_pipe_ok = 2'b11;
      wr_cfg(1, d1, d2, 32'h0);
      pwr_req = 1'b1;
      for (int n = 1; n <= lim; n++) begin
         if (midwr && n == 2) begin
            cfg_wdata = (32'd1 << 30); cfg_wr = 1'b1;
         end
         @(negedge clk);
         cfg_wr = 1'b0;
         if (n == 1) chk(seq_status == 2'b01, "R3 status busy", seq_status, 1);
         if (panel_pwr && t_pwr < 0) t_pwr = n;
         if (panel_rdy && t_rdy < 0) t_rdy = n;
         if (backlight_en && t_bl < 0) t_bl = n;
      end
      chk(t_pwr == 1, "R3 power rise", t_pwr, 1);
      chk(t_rdy == e_rdy, req, t_rdy, e_rdy);
      chk(t_bl == e_bl, req, t_bl, e_bl);
      chk(seq_status == 2'b10, "R5 status on", seq_status, 2);
      pwr_req = 1'b0;
      @(negedge clk);
      chk(!panel_pwr && !panel_rdy && !backlight_en && seq_status == 2'b00,
          "R7 request drop", {panel_pwr, panel_rdy, backlight_en}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!panel_pwr && !panel_rdy && !backlight_en && seq_status == 0 && !blocked_flag,
          "R1 reset outputs", {panel_pwr, backlight_en, blocked_flag}, 0);
      // R1: zero reset value means port code 00 and the request is refused
      port_en = 2'b11; port_pipe_ok = 2'b11; pwr_req = 1'b1;
      repeat (2) @(negedge clk);
      chk(!panel_pwr, "R1 reset refuses", panel_pwr, 0);
      chk(blocked_flag, "R9 blocked set", blocked_flag, 1);
      pwr_req = 1'b0;
      repeat (3) @(negedge clk);
      chk(blocked_flag, "R9 sticky hold", blocked_flag, 1);
      wr_cfg(0, 0, 0, 32'h0);
      chk(!blocked_flag, "R9 write clears", blocked_flag, 0);

      // R2 / R9: sweep all port codes and status combinations
      for (int s = 0; s < 4; s++)
         for (int e = 0; e < 4; e++)
            for (int p = 0; p < 4; p++) begin
               bit ok;
               ok = (s == 1 && e[0] && p[0]) || (s == 2 && e[1] && p[1]);
               port_en = 2'(e); port_pipe_ok = 2'(p);
               wr_cfg(s, 0, 0, 32'h0);
               pwr_req = 1'b1;
               repeat (2) @(negedge clk);
               chk(panel_pwr == ok, "R2 port validity", panel_pwr, ok);
               chk(blocked_flag == !ok, "R9 blocked on invalid", blocked_flag, !ok);
               pwr_req = 1'b0;
               repeat (2) @(negedge clk);
            end

      // R4 R5 R6: delay sweep including zero
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            run_seq(a, b, 1'b0, "R4 R5 R6 delay timing");
      run_seq(8191, 2, 1'b0, "R4 largest delay");
      // R8: a write mid-sequence leaves the running timing alone
      run_seq(3, 2, 1'b1, "R8 captured delays");

      // R1: reserved bits 29 and 15:13 have no effect
      run_seq(1, 1, 1'b0, "R1 baseline");
      port_en = 2'b11; port_pipe_ok = 2'b11;
      wr_cfg(1, 2, 1, 32'h2000_E000);
      pwr_req = 1'b1;
      for (int n = 1; n <= 1 + 3 * DIV; n++) begin
         @(negedge clk);
         if (n == 2 * DIV) chk(!panel_rdy, "R1 reserved early", panel_rdy, 0);
         if (n == 1 + 2 * DIV) chk(panel_rdy && !backlight_en, "R1 reserved rdy", panel_rdy, 1);
         if (n == 3 * DIV) chk(!backlight_en, "R1 reserved bl early", backlight_en, 0);
      end
      chk(backlight_en, "R1 reserved bl", backlight_en, 1);

      // R7: loss of port enable while on
      port_en = 2'b10;
      @(negedge clk);
      chk(!panel_pwr && !backlight_en && seq_status == 0, "R7 enable loss", panel_pwr, 0);
      // R7: loss of pipe routing while powering up
      port_en = 2'b11;
      repeat (2) @(negedge clk);
      chk(panel_pwr && !panel_rdy, "R7 restart busy", panel_pwr, 1);
      port_pipe_ok = 2'b10;
      @(negedge clk);
      chk(!panel_pwr && seq_status == 0, "R7 pipe loss", panel_pwr, 0);
      pwr_req = 1'b0;
      @(negedge clk);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule